// File: doc/BRIEF.md
# External Memory Bus Cycle Sequencer

This block runs bus cycles on an external 16-bit memory bus on behalf of one internal master. The master presents an address, write data, a direction bit and byte enables. The block then walks a fixed sequence of bus states: a first state T1, a second state T2, any number of inserted wait states TW, and a final state T3. It drives an active-low address latch strobe, an active-low read strobe and one active-low write strobe per data byte. Read data is returned together with a done pulse.

Two bus layouts are supported, chosen by a mode input.

- **Multiplexed mode:** the address and the data share one set of pins. The low address bits go out during T1, and the data follows in the later states.
- **Separate mode:** the address has its own output pins and stays on them for the whole cycle.

An external wait input can stretch the cycle while an enable bit allows it. Where that input is sampled depends on the mode:

- In multiplexed mode it is sampled on falling clock edges.
- In separate mode it is sampled on rising clock edges.

The address strobe moves on falling clock edges, so it changes in the middle of a bus state.

Top module: `ext_bus_seq`

## Requirements
- R1: After reset the block is idle: `rsp_done` is 0, `req_ready` is 1, and `bus_astb_n`, `bus_rd_n` and every bit of `bus_wr_n` are 1.
- R2: With no wait inserted, an accepted request runs T1, T2 and T3 on the three clocks after acceptance, and `rsp_done` is high in the third of them.
- R3: In multiplexed mode, `bus_wait` is sampled on the falling clock edge inside T2 and inside each TW. A high sample (with the wait function on) makes the next state a TW; a low sample makes it T3.
- R4: In separate mode, `bus_wait` is sampled on the rising edge that opens T2 and on the rising edge that opens each TW. That sample decides whether the state it opens is followed by a TW or by T3.
- R5: While `wait_en` is 0, `bus_wait` has no effect and T2 is always followed by T3.
- R6: `bus_astb_n` falls on the falling clock edge inside T1 and rises on the falling clock edge inside T3. It is 1 whenever no bus cycle is in progress.
- R7: For a read, `bus_rd_n` is 0 from the start of T2 to the end of the last TW (or of T2 if there is no TW), and all write strobes stay 1.
- R8: For a write, `bus_wr_n[0]` (low data byte) is 0 over the same window when `req_be[0]` was 1. `bus_wr_n[1]` (high data byte) does the same for `req_be[1]`, so both strobes fall together for a halfword write. `bus_rd_n` stays 1.
- R9: In multiplexed mode, `bus_ad_out` carries the low 16 address bits with `bus_ad_oe`=1 during T1. From T2 through T3, `bus_ad_oe` is 0 for reads, and for writes it is 1 with the write data on `bus_ad_out`.
- R10: In separate mode, `bus_addr` holds the request address from T1 through T3. For writes, `bus_ad_oe` is 1 with the write data from T1 through T3; for reads, `bus_ad_oe` is 0.
- R11: Read data on `bus_ad_in` is captured at the end of T2 or of the final TW, and is presented on `rsp_rdata` during T3, where `rsp_done` is high for that one cycle only.
- R12: `req_ready` is 1 only in idle and in T3. A request accepted in T3 makes the next cycle T1, with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mux_mode | input | 1 | 1 = multiplexed address/data, 0 = separate address bus |
| wait_en | input | 1 | Wait function enable |
| req_valid | input | 1 | Master request |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte enables, bit 0 low byte |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | High during T3 |
| rsp_rdata | output | 16 | Captured read data |
| bus_wait | input | 1 | External wait request, active high |
| bus_astb_n | output | 1 | Address latch strobe, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 2 | Byte write strobes, active low |
| bus_addr | output | ADDR_W | Separate address bus |
| bus_ad_out | output | 16 | Address/data output |
| bus_ad_oe | output | 1 | Output enable for bus_ad_out |
| bus_ad_in | input | 16 | Data input from the bus |

## Verification
The bench sweeps both bus modes, both wait-enable settings, reads and writes, all three byte-enable patterns and zero to three wait states. It times the wait input so that exactly the intended samples are high. A design that samples on the wrong edge or in the wrong state for a mode ends up with one wait state too many or too few, so the strobe window and the done cycle land off by one. The bench also checks the strobe on both halves of each clock, which exposes an address strobe moved on rising edges. A back-to-back pair catches a sequencer that wastes an idle cycle after T3. Holding the wait input high with the enable off catches a design that fails to gate it.

// File: rtl/ebus_pkg.sv
package ebus_pkg;
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_T1   = 3'd1,
    S_T2   = 3'd2,
    S_TW   = 3'd3,
    S_T3   = 3'd4
  } bus_st_e;

  // States in which the strobes are active and wait is evaluated
  function automatic logic strobe_window(bus_st_e s);
    return (s == S_T2) || (s == S_TW);
  endfunction

  // States in which a new request may be taken
  function automatic logic can_accept(bus_st_e s);
    return (s == S_IDLE) || (s == S_T3);
  endfunction
endpackage

// File: rtl/ebus_wait_sampler.sv
module ebus_wait_sampler
  import ebus_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    mux_mode,
  input  logic    wait_en,
  input  logic    wait_in,
  input  bus_st_e st,
  output logic    wait_hit
);
  logic fall_smp;   // multiplexed: falling edge inside T2/TW
  logic rise_smp;   // separate: rising edge opening the current state

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_smp <= 1'b0;
    else        fall_smp <= strobe_window(st) & wait_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rise_smp <= 1'b0;
    else        rise_smp <= wait_in;
  end

  assign wait_hit = wait_en & (mux_mode ? fall_smp : rise_smp);

  // The falling-edge sample taken during T3 or idle is always clear when T1 begins
  p_no_early_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_T1) |-> !fall_smp);
endmodule

// File: rtl/ebus_astb_gen.sv
module ebus_astb_gen
  import ebus_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  bus_st_e st,
  output logic    astb_n
);
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)                            astb_n <= 1'b1;
    else if (st == S_T1)                   astb_n <= 1'b0;
    else if (st == S_T3 || st == S_IDLE)   astb_n <= 1'b1;
  end

  p_astb_low_t2_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_T2) |-> !astb_n);
  p_astb_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> astb_n);
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
  import ebus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mux_mode,
  input  logic                  wait_en,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_we,
  input  logic [DATA_W/8-1:0]   req_be,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic                  rsp_done,
  output logic [DATA_W-1:0]     rsp_rdata,
  input  logic                  bus_wait,
  output logic                  bus_astb_n,
  output logic                  bus_rd_n,
  output logic [DATA_W/8-1:0]   bus_wr_n,
  output logic [ADDR_W-1:0]     bus_addr,
  output logic [DATA_W-1:0]     bus_ad_out,
  output logic                  bus_ad_oe,
  input  logic [DATA_W-1:0]     bus_ad_in
);
  localparam int NBYTE = DATA_W / 8;

  bus_st_e             st, nxt;
  logic                wait_hit;
  logic                accept;
  logic                win;
  logic                last_data_state;
  logic                we_q;
  logic [NBYTE-1:0]    be_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wdata_q;
  logic [DATA_W-1:0]   rdata_q;

  assign req_ready       = can_accept(st);
  assign accept          = req_ready & req_valid;
  assign win             = strobe_window(st);
  assign last_data_state = win & !wait_hit;

  always_comb begin
    nxt = st;
    unique case (st)
      S_IDLE:     nxt = req_valid ? S_T1 : S_IDLE;
      S_T1:       nxt = S_T2;
      S_T2, S_TW: nxt = wait_hit ? S_TW : S_T3;
      S_T3:       nxt = req_valid ? S_T1 : S_IDLE;
      default:    nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      we_q    <= 1'b0;
      be_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      st <= nxt;
      if (accept) begin
        we_q    <= req_we;
        be_q    <= req_be;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (last_data_state && !we_q) rdata_q <= bus_ad_in;
    end
  end

  ebus_wait_sampler u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .mux_mode (mux_mode),
    .wait_en  (wait_en),
    .wait_in  (bus_wait),
    .st       (st),
    .wait_hit (wait_hit)
  );

  ebus_astb_gen u_astb (
    .clk    (clk),
    .rst_n  (rst_n),
    .st     (st),
    .astb_n (bus_astb_n)
  );

  assign bus_rd_n = !(win && !we_q);

  for (genvar i = 0; i < NBYTE; i++) begin : g_wr
    assign bus_wr_n[i] = !(win && we_q && be_q[i]);
  end

  always_comb begin
    if (mux_mode) bus_ad_oe = (st == S_T1) || (we_q && (win || st == S_T3));
    else          bus_ad_oe = we_q && (st != S_IDLE);
  end

  assign bus_ad_out = (mux_mode && st == S_T1) ? addr_q[DATA_W-1:0] : wdata_q;
  assign bus_addr   = addr_q;
  assign rsp_done   = (st == S_T3);
  assign rsp_rdata  = rdata_q;

  p_t1_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_T1) |=> (st == S_T2));
  p_wait_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wait_en && st == S_T2) |=> (st == S_T3));
  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && (bus_wr_n != '1)));
  p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st inside {S_T2, S_TW, S_T3}) |-> $stable(bus_addr));
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  p_chain_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_T3 && req_valid) |=> (st == S_T1));
endmodule

// File: tb/ext_bus_seq_bench.sv
module ext_bus_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mux_mode = 1'b0;
  logic        wait_en = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_we = 1'b0;
  logic [1:0]  req_be = 2'b00;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_done;
  logic [15:0] rsp_rdata;
  logic        bus_wait = 1'b0;
  logic        bus_astb_n;
  logic        bus_rd_n;
  logic [1:0]  bus_wr_n;
  logic [19:0] bus_addr;
  logic [15:0] bus_ad_out;
  logic        bus_ad_oe;
  logic [15:0] bus_ad_in = '0;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  ext_bus_seq #(.ADDR_W(20), .DATA_W(16)) u_ext_bus_seq (
    .clk(clk), .rst_n(rst_n), .mux_mode(mux_mode), .wait_en(wait_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_be(req_be), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .bus_wait(bus_wait),
    .bus_astb_n(bus_astb_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_addr(bus_addr), .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe),
    .bus_ad_in(bus_ad_in)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  // Expected count of wait states: sample high means one more TW
  function automatic int eff_waits(input bit wen, input int k);
    return wen ? k : 0;
  endfunction

  // Wait level to drive in cycle c after acceptance (c=0 is T1)
  function automatic bit wait_level(input bit mm, input bit wen, input int c, input int k);
    if (!wen) return 1'b1;
    return mm ? (c <= k) : (c < k);
  endfunction

  // Called at 5 ns after a rising edge; returns at the same phase
  task automatic run_txn(input bit mm, input bit wen, input bit w, input bit [1:0] b,
                         input bit [19:0] a, input bit [15:0] wd, input bit [15:0] rp,
                         input int k, input bit chain_prev, input bit chain_next);
    int  ke;
    bit  win;
    bit  oe_exp;
    string tm;
    ke = eff_waits(wen, k);
    tm = (!wen && k > 0) ? "R5" : (k == 0) ? "R2" : (mm ? "R3" : "R4");
    bus_ad_in = rp;
    if (!chain_prev) begin
      mux_mode  = mm;
      wait_en   = wen;
      chk("R12", {31'd0, req_ready}, 32'd1);
      req_valid = 1'b1;
      req_we    = w;
      req_be    = b;
      req_addr  = a;
      req_wdata = wd;
      @(posedge clk); #5;
      req_valid = 1'b0;
    end
    for (int c = 0; c <= ke + 2; c++) begin
      if (c > 0) begin @(posedge clk); #5; end
      bus_wait = wait_level(mm, wen, c, k);
      win = (c >= 1) && (c <= ke + 1);
      chk("R7", {31'd0, bus_rd_n}, {31'd0, !(win && !w)});
      chk("R8", {30'd0, bus_wr_n}, {30'd0, !(win && w && b[1]), !(win && w && b[0])});
      chk(tm, {31'd0, rsp_done}, {31'd0, c == ke + 2});
      chk("R12", {31'd0, req_ready}, {31'd0, c == ke + 2});
      chk("R6", {31'd0, bus_astb_n}, {31'd0, c == 0});
      oe_exp = mm ? (c == 0 || w) : w;
      chk(mm ? "R9" : "R10", {31'd0, bus_ad_oe}, {31'd0, oe_exp});
      if (oe_exp)
        chk(mm ? "R9" : "R10", {16'd0, bus_ad_out}, {16'd0, (mm && c == 0) ? a[15:0] : wd});
      chk("R10", {12'd0, bus_addr}, {12'd0, a});
      if (c == ke + 2 && !w) chk("R11", {16'd0, rsp_rdata}, {16'd0, rp});
      if (c == ke + 2 && chain_next) req_valid = 1'b1;
      #10;
      chk("R6", {31'd0, bus_astb_n}, {31'd0, c == ke + 2});
    end
    @(posedge clk); #5;
    bus_wait = 1'b0;
    if (chain_next) begin
      req_valid = 1'b0;
    end else begin
      chk("R11", {31'd0, rsp_done}, 32'd0);
      chk("R12", {31'd0, req_ready}, 32'd1);
      chk("R6", {31'd0, bus_astb_n}, 32'd1);
      chk("R7", {31'd0, bus_rd_n}, 32'd1);
    end
  endtask

  initial begin
    #2000000;
    bad++;
    total++;
    $display("FAIL R1 watchdog expired: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int idx;
    repeat (3) @(posedge clk);
    #5;
    rst_n = 1'b1;
    chk("R1", {31'd0, rsp_done}, 32'd0);
    chk("R1", {31'd0, req_ready}, 32'd1);
    chk("R1", {31'd0, bus_astb_n}, 32'd1);
    chk("R1", {31'd0, bus_rd_n}, 32'd1);
    chk("R1", {30'd0, bus_wr_n}, 32'd3);
    @(posedge clk); #5;
    idx = 0;
    for (int mm = 0; mm < 2; mm++)
      for (int wen = 0; wen < 2; wen++)
        for (int w = 0; w < 2; w++)
          for (int k = 0; k < 4; k++) begin
            run_txn(mm[0], wen[0], w[0], w[0] ? 2'((k % 3) + 1) : 2'b11,
                    20'h5A3C1 ^ 20'(idx * 37), 16'hA500 + 16'(idx), 16'h3C00 + 16'(idx * 5),
                    k, 1'b0, 1'b0);
            idx++;
          end
    // Back-to-back pairs, request taken in T3 (R12)
    for (int mm = 0; mm < 2; mm++) begin
      run_txn(mm[0], 1'b1, 1'b0, 2'b11, 20'h0F0F0, 16'h1111, 16'hBEEF, 1, 1'b0, 1'b1);
      run_txn(mm[0], 1'b1, 1'b0, 2'b11, 20'h0F0F0, 16'h1111, 16'hBEEF, 1, 1'b1, 1'b0);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule